// File: doc/BRIEF.md
# Serial Bus Pause Qualifier

This block sits between the synchronized chip-select, serial-clock, data-in and pause pins of a serial memory slave and its bit-level serial engine. It decides, one system clock at a time, whether the transfer in progress is suspended. While it is suspended, no serial-clock edge strobe reaches the engine, the data-in value seen by the engine is frozen, and the data-out driver is forced to high impedance. The engine's bit position is left untouched, so the transfer carries on from the same bit once the pause ends.

Entering and leaving the pause depend on the level of the serial clock. A pause request made while the clock is low takes effect at once. A request made while the clock is high waits for the clock to fall. A release counts only when the pause pin rises while the clock is low. Deselecting the device ends any pause and raises a one-cycle pulse that tells the engine to drop its sequence.

All inputs are already synchronized to `clk_i`. Edge strobes and the pause flag are combinational from the current samples and one register stage of history, so the engine sees them in the same cycle as the sampled pin change.

Top module: `spi_hold_qual`

## Requirements
- R1: After reset, with the device deselected, `paused_o` is 0, both strobes are 0 and `so_hiz_o` is 1.
- R2: While selected and not paused, `sck_rise_o` is 1 for exactly the cycle in which `sck_i` is first sampled 1 after a 0, and `sck_fall_o` likewise for 1 to 0. `si_o` equals `si_i`.
- R3: While selected, a cycle that samples `hold_ni` low and `sck_i` low shows `paused_o` at 1 in that same cycle, and no strobe is given in that cycle.
- R4: A `hold_ni` low level sampled while `sck_i` is high does not pause. The pause begins in the first cycle that samples `sck_i` low, and the falling strobe of that cycle is suppressed.
- R5: While `paused_o` is 1, neither strobe is given, whatever `sck_i` does, and `si_o` keeps the value it had in the cycle before the pause began.
- R6: A rise of `hold_ni` sampled while `sck_i` is low ends the pause. `paused_o` is still 1 and no strobe is given in that release cycle, and `paused_o` is 0 from the next cycle.
- R7: A rise of `hold_ni` sampled while `sck_i` is high does not end the pause. The pause remains even after `sck_i` later goes low with `hold_ni` still high. A fresh low-then-high on `hold_ni` with `sck_i` low is needed.
- R8: `so_hiz_o` is 1 whenever `hold_ni` is low, `cs_ni` is high, or `paused_o` is 1.
- R9: While `cs_ni` is high, `paused_o` and both strobes are 0. A deselect clears any pause. `seq_clr_o` is 1 for exactly the one cycle in which `cs_ni` is first sampled high after being low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Synchronized chip select, active low |
| sck_i | input | 1 | Synchronized serial clock level |
| si_i | input | 1 | Synchronized serial data in |
| hold_ni | input | 1 | Synchronized pause request, active low |
| sck_rise_o | output | 1 | Gated serial-clock rising-edge strobe to the engine |
| sck_fall_o | output | 1 | Gated serial-clock falling-edge strobe to the engine |
| si_o | output | 1 | Data-in value for the engine, frozen during a pause |
| paused_o | output | 1 | Transfer is suspended |
| so_hiz_o | output | 1 | Override forcing the data-out driver to high impedance |
| seq_clr_o | output | 1 | One-cycle pulse: deselect, engine drops its sequence |

## Verification
The properties assume that the inputs are clean single-clock-domain samples. They also assume that `hold_ni` and `cs_ni` are high while reset is active, because the checks that look one cycle back take the reset-time pause flag as their starting point. The bench drives every input on the falling system-clock edge and holds both pins high through reset. It changes `sck_i` at most once per system cycle, so each serial-clock level lasts at least one sampled cycle, as the edge strobes require.

// File: rtl/spi_hold_qual_pkg.sv
package spi_hold_qual_pkg;
  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_PAUSE = 1'b1
  } pause_st_e;

  localparam int unsigned PIN_SCK  = 0;
  localparam int unsigned PIN_HOLD = 1;
  localparam int unsigned PIN_CS   = 2;
  localparam int unsigned NUM_PINS = 3;
endpackage

// File: rtl/hq_pin_hist.sv
// One-cycle history of the sampled pins, per-bit reset value.
module hq_pin_hist #(
  parameter int unsigned            W       = 3,
  parameter logic        [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] prev_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_o[g] <= RST_VAL[g];
      else         prev_o[g] <= pin_i[g];
    end
  end
endmodule

// File: rtl/hq_pause_fsm.sv
module hq_pause_fsm
  import spi_hold_qual_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic sck_i,
  input  logic hold_ni,
  input  logic hold_rise_i,
  output logic paused_o,
  output logic block_o
);
  pause_st_e st_q, st_d;
  logic      enter;

  // a low pause pin only takes effect on a low clock level
  assign enter = ~hold_ni & ~sck_i;

  always_comb begin
    st_d = st_q;
    if (!sel_i) begin
      st_d = ST_RUN;
    end else begin
      unique case (st_q)
        ST_RUN:   if (enter) st_d = ST_PAUSE;
        ST_PAUSE: if (hold_rise_i && !sck_i) st_d = ST_RUN;
        default:  st_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_RUN;
    else         st_q <= st_d;
  end

  // release cycle is still inside ST_PAUSE, so its edge stays blocked
  assign paused_o = sel_i & ((st_q == ST_PAUSE) | enter);
  assign block_o  = ~sel_i | paused_o;
endmodule

// File: rtl/hq_si_freeze.sv
module hq_si_freeze (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic si_i,
  input  logic frz_i,
  output logic si_o
);
  logic si_q;

  assign si_o = frz_i ? si_q : si_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) si_q <= 1'b0;
    else         si_q <= si_o;
  end
endmodule

// File: rtl/spi_hold_qual.sv
module spi_hold_qual
  import spi_hold_qual_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  input  logic hold_ni,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic si_o,
  output logic paused_o,
  output logic so_hiz_o,
  output logic seq_clr_o
);
  localparam logic [NUM_PINS-1:0] HIST_RST = (NUM_PINS'(1) << PIN_CS) | (NUM_PINS'(1) << PIN_HOLD);

  logic [NUM_PINS-1:0] pins, prev;
  logic                sel, blk, hold_rise, raw_rise, raw_fall;

  assign pins[PIN_SCK]  = sck_i;
  assign pins[PIN_HOLD] = hold_ni;
  assign pins[PIN_CS]   = cs_ni;

  hq_pin_hist #(.W(NUM_PINS), .RST_VAL(HIST_RST)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pins),
    .prev_o (prev)
  );

  assign sel       = ~cs_ni;
  assign raw_rise  =  sck_i & ~prev[PIN_SCK];
  assign raw_fall  = ~sck_i &  prev[PIN_SCK];
  assign hold_rise =  hold_ni & ~prev[PIN_HOLD];

  hq_pause_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (sel),
    .sck_i       (sck_i),
    .hold_ni     (hold_ni),
    .hold_rise_i (hold_rise),
    .paused_o    (paused_o),
    .block_o     (blk)
  );

  hq_si_freeze u_si (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .si_i   (si_i),
    .frz_i  (paused_o),
    .si_o   (si_o)
  );

  assign sck_rise_o = raw_rise & ~blk;
  assign sck_fall_o = raw_fall & ~blk;
  assign so_hiz_o   = cs_ni | ~hold_ni | paused_o;
  assign seq_clr_o  = cs_ni & ~prev[PIN_CS];
endmodule

// File: rtl/spi_hold_qual_chk.sv
module spi_hold_qual_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic sck_i,
  input logic si_i,
  input logic hold_ni,
  input logic sck_rise_o,
  input logic sck_fall_o,
  input logic si_o,
  input logic paused_o,
  input logic so_hiz_o,
  input logic seq_clr_o
);
  p_low_clk_enter_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !hold_ni && !sck_i) |-> paused_o);

  p_no_strobe_paused_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused_o |-> (!sck_rise_o && !sck_fall_o));

  p_si_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paused_o && $past(paused_o)) |-> $stable(si_o));

  p_strobe_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sck_rise_o, sck_fall_o}));

  p_stay_paused_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(paused_o) && !$past(cs_ni) && !cs_ni &&
     !($past(hold_ni) && !$past(sck_i) && !$past(hold_ni, 2))) |-> paused_o);

  p_hiz_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_ni || cs_ni || paused_o) |-> so_hiz_o);

  p_desel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> (!paused_o && !sck_rise_o && !sck_fall_o));

  p_clr_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_clr_o |=> !seq_clr_o);
endmodule

bind spi_hold_qual spi_hold_qual_chk u_chk (.*);

// File: tb/spi_hold_qual_bench.sv
`timescale 1ns/1ps
module spi_hold_qual_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic rise, fall, si_q, paused, hiz, clr;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  spi_hold_qual u_spi_hold_qual (
    .clk_i (clk), .rst_ni (rst_n), .cs_ni (cs_n), .sck_i (sck), .si_i (si),
    .hold_ni (hold_n), .sck_rise_o (rise), .sck_fall_o (fall), .si_o (si_q),
    .paused_o (paused), .so_hiz_o (hiz), .seq_clr_o (clr)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // drive on falling edge, outputs settle before next rising edge
  task automatic step(input logic c, input logic k, input logic h, input logic d);
    @(negedge clk);
    cs_n = c; sck = k; hold_n = h; si = d;
    #1;
  endtask

  task automatic t_reset;
    chk("R1", "paused in reset", paused, 1'b0);
    chk("R1", "hiz in reset", hiz, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    step(1, 0, 1, 0);
    chk("R1", "paused", paused, 1'b0);
    chk("R1", "rise", rise, 1'b0);
    chk("R1", "fall", fall, 1'b0);
    chk("R8", "hiz deselected", hiz, 1'b1);
  endtask

  task automatic t_run;
    step(0, 0, 1, 1);
    chk("R8", "hiz selected", hiz, 1'b0);
    step(0, 1, 1, 1);
    chk("R2", "rise", rise, 1'b1);
    chk("R2", "si pass", si_q, 1'b1);
    step(0, 1, 1, 0);
    chk("R2", "rise one cycle", rise, 1'b0);
    chk("R2", "si pass low", si_q, 1'b0);
    step(0, 0, 1, 1);
    chk("R2", "fall", fall, 1'b1);
  endtask

  task automatic t_low_clk_pause;
    step(0, 0, 0, 0);
    chk("R3", "paused same cycle", paused, 1'b1);
    chk("R8", "hiz hold low", hiz, 1'b1);
    step(0, 1, 0, 0);
    chk("R5", "rise blocked", rise, 1'b0);
    chk("R5", "si frozen", si_q, 1'b1);
    step(0, 0, 0, 0);
    chk("R5", "fall blocked", fall, 1'b0);
    step(0, 0, 1, 0);
    chk("R6", "paused in release cycle", paused, 1'b1);
    chk("R8", "hiz release cycle", hiz, 1'b1);
    step(0, 0, 1, 0);
    chk("R6", "resumed", paused, 1'b0);
    chk("R6", "si live again", si_q, 1'b0);
    step(0, 1, 1, 0);
    chk("R6", "rise after resume", rise, 1'b1);
  endtask

  task automatic t_defer;
    step(0, 1, 0, 0);
    chk("R4", "not paused on high clock", paused, 1'b0);
    chk("R8", "hiz on hold low", hiz, 1'b1);
    step(0, 0, 0, 0);
    chk("R4", "paused at clock fall", paused, 1'b1);
    chk("R4", "fall suppressed", fall, 1'b0);
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    chk("R6", "resumed", paused, 1'b0);
  endtask

  task automatic t_bad_release;
    step(0, 0, 0, 0);
    step(0, 1, 0, 0);
    step(0, 1, 1, 0);
    chk("R7", "release on high clock", paused, 1'b1);
    step(0, 0, 1, 0);
    chk("R7", "still paused after clock low", paused, 1'b1);
    chk("R7", "fall blocked", fall, 1'b0);
    step(0, 0, 1, 0);
    chk("R7", "still paused later", paused, 1'b1);
    step(0, 0, 0, 0);
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    chk("R7", "resumed after fresh release", paused, 1'b0);
  endtask

  task automatic t_deselect;
    step(0, 0, 0, 0);
    chk("R9", "paused before deselect", paused, 1'b1);
    step(1, 1, 0, 0);
    chk("R9", "pause cleared", paused, 1'b0);
    chk("R9", "clr pulse", clr, 1'b1);
    chk("R9", "rise blocked deselected", rise, 1'b0);
    step(1, 0, 1, 0);
    chk("R9", "clr one cycle", clr, 1'b0);
    chk("R9", "fall blocked deselected", fall, 1'b0);
    step(0, 0, 1, 0);
    chk("R9", "no pause after reselect", paused, 1'b0);
    step(0, 1, 1, 0);
    chk("R9", "rise after reselect", rise, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    t_run;
    t_low_clk_pause;
    t_defer;
    t_bad_release;
    t_deselect;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule